// File: doc/BRIEF.md
# Multi-format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel sample pairs. It runs directly on the incoming bit clock and watches a frame clock and a data line. From these it recovers one left word and one right word per frame. Four framings are accepted: I2S, left-justified, right-justified, and a DSP-style framing in which a single-slot frame pulse marks the start of a frame. The word length is 16, 20 or 24 bits. Words arrive MSB first in two's complement, and every result is sign-extended to 24 bits.

The bit clock may run continuously at 64 slots per frame, or it may stop between bursts. All behaviour is counted in rising bit-clock edges, so a stopped clock only freezes the block. After reset nothing is captured until the first rising frame-clock edge has been sampled. When a frame's left word and then its right word have both been collected, the pair appears on the outputs together with a one-slot valid pulse.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is low, and after its release, both sample outputs read 0 and the valid output is low. Capture starts only at the first rising frame-clock edge sampled after reset. The first bit-clock edge after release only records the frame level, so a high level at release is not treated as an edge.
- R2: Format code 0 (I2S, the zero code): a frame-clock low half carries the left word and a high half carries the right word. The MSB is sampled on the second rising bit-clock edge of the half, counting the edge that first sees the new level as the first.
- R3: Format code 1 (left-justified): a frame-clock high half carries the left word and a low half carries the right word. The MSB is sampled on the edge that first sees the new level.
- R4: Format code 2 (right-justified): high is left and low is right. The LSB of each word is the last bit sampled before the frame clock changes, and the word is taken at the edge that sees the change. A half that ended before capture started is discarded.
- R5: Format code 3 (DSP): a rising frame-clock edge, one slot wide, marks the frame. The left MSB follows on the next edge, the right MSB follows the left LSB directly, and the falling frame-clock edge has no effect on slot counting.
- R6: Length code 0 selects 24 bits, 1 selects 20, 2 selects 16, and 3 also selects 24. Bits that fall outside the selected word positions do not change the result.
- R7: A word shorter than 24 bits is sign-extended, so bits above its MSB copy its MSB.
- R8: The valid output is high for exactly one bit-clock cycle. It rises after the edge that takes the right word, and only if a left word was taken after the last pair. Both sample outputs change only together with that pulse and otherwise hold their values.
- R9: Stopping the bit clock for any time between edges changes neither the outputs nor the recovered words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Serial bit clock, rising edge samples frame clock and data |
| rstN | input | 1 | Asynchronous active-low reset |
| frameClk | input | 1 | Frame clock (channel level or DSP frame pulse) |
| serData | input | 1 | Serial data, MSB first |
| fmtSel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| lenSel | input | 2 | Word length: 0 or 3 = 24, 1 = 20, 2 = 16 |
| leftData | output | 24 | Sign-extended left sample of the last pair |
| rightData | output | 24 | Sign-extended right sample of the last pair |
| pairValid | output | 1 | One-cycle pulse marking a new pair |

## Verification
Start-up is the hardest part to reach from the ports. In I2S the arming edge opens a right half with no left word before it, so that first right word must be dropped. In right-justified mode the half that closes at the arming edge must be ignored. Every segment therefore starts with a fresh reset and an idle frame level, sometimes high, so that the first frame is deliberately partial. Stalled-clock behaviour is reached by pausing the bench's bit clock in the middle of words at a fixed slot interval, with a comparison made during each pause.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  // step between supported word lengths (24, 20, 16)
  localparam int LEN_STEP = 4;
  localparam int LEN_VARIANTS = 3;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capLeft;   // store current word as pending left
    logic       emitPair;  // current word is right: publish pair
    logic       useHeld;   // word is in held shift contents (no new bit)
    logic [1:0] lenIdx;    // 0: full, 1: minus one step, 2: minus two steps
  } strobes_t;

endpackage

// File: rtl/serial_audio_rx_ctrl.sv
module serial_audio_rx_ctrl
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 7
) (
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       frameClk,
  input  logic [1:0] fmtSel,
  input  logic [1:0] lenSel,
  output strobes_t   strobes
);

  localparam int MID_W   = SAMPLE_W - LEN_STEP;
  localparam int SHORT_W = SAMPLE_W - 2 * LEN_STEP;
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
  localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);

  fmt_e fmt;
  assign fmt = fmt_e'(fmtSel);

  logic              prevFrame;
  logic              havePrev;
  logic              started;
  logic              leftHave;
  logic [SLOT_W-1:0] slotReg;
  logic [SLOT_W-1:0] slotNow;
  logic [SLOT_W-1:0] wordLen;
  logic              riseNow;
  logic              fallNow;
  logic              restartNow;
  logic              activeNow;
  logic              capL;
  logic              capR;
  logic              useHeld;
  logic              emit;
  logic [1:0]        lenIdx;

  // edge detection and slot position within the current half / frame
  always_comb begin
    riseNow    = havePrev && frameClk && !prevFrame;
    fallNow    = havePrev && !frameClk && prevFrame;
    restartNow = (fmt == FMT_DSP) ? riseNow : (riseNow || fallNow);
    if (restartNow) begin
      slotNow = '0;
    end else if (slotReg == SLOT_MAX) begin
      slotNow = slotReg;
    end else begin
      slotNow = slotReg + SLOT_ONE;
    end
    activeNow = started || riseNow;
  end

  always_comb begin
    case (lenSel)
      2'd1:    begin wordLen = SLOT_W'(MID_W);    lenIdx = 2'd1; end
      2'd2:    begin wordLen = SLOT_W'(SHORT_W);  lenIdx = 2'd2; end
      default: begin wordLen = SLOT_W'(SAMPLE_W); lenIdx = 2'd0; end
    endcase
  end

  // capture decision per framing
  always_comb begin
    capL    = 1'b0;
    capR    = 1'b0;
    useHeld = 1'b0;
    case (fmt)
      FMT_I2S: begin
        if (activeNow && slotNow == wordLen) begin
          capL = !frameClk;
          capR = frameClk;
        end
      end
      FMT_LJ: begin
        if (activeNow && slotNow == wordLen - SLOT_ONE) begin
          capL = frameClk;
          capR = !frameClk;
        end
      end
      FMT_RJ: begin
        useHeld = 1'b1;
        if (started && (riseNow || fallNow)) begin
          capL = prevFrame;
          capR = !prevFrame;
        end
      end
      default: begin
        if (activeNow) begin
          capL = (slotNow == wordLen);
          capR = (slotNow == (wordLen << 1));
        end
      end
    endcase
    emit = capR && leftHave;
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      prevFrame <= 1'b0;
      havePrev  <= 1'b0;
      started   <= 1'b0;
      leftHave  <= 1'b0;
      slotReg   <= SLOT_MAX;
    end else begin
      prevFrame <= frameClk;
      havePrev  <= 1'b1;
      slotReg   <= slotNow;
      if (riseNow) begin
        started <= 1'b1;
      end
      if (emit) begin
        leftHave <= 1'b0;
      end else if (capL) begin
        leftHave <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.capLeft  = capL;
    strobes.emitPair = emit;
    strobes.useHeld  = useHeld;
    strobes.lenIdx   = lenIdx;
  end

endmodule

// File: rtl/serial_audio_rx_dp.sv
module serial_audio_rx_dp
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                serData,
  input  strobes_t            strobes,
  output logic [SAMPLE_W-1:0] leftData,
  output logic [SAMPLE_W-1:0] rightData,
  output logic                pairValid
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] shiftNext;
  logic [SAMPLE_W-1:0] rawWord;
  logic [SAMPLE_W-1:0] extWord;
  logic [SAMPLE_W-1:0] pendLeft;
  logic [SAMPLE_W-1:0] extCand [LEN_VARIANTS];

  assign shiftNext = {shiftReg[SAMPLE_W-2:0], serData};
  assign rawWord   = strobes.useHeld ? shiftReg : shiftNext;

  // one sign-extension variant per supported word length
  for (genvar g = 0; g < LEN_VARIANTS; g++) begin : g_ext
    localparam int LEN = SAMPLE_W - g * LEN_STEP;
    assign extCand[g] = SAMPLE_W'(signed'(rawWord[LEN-1:0]));
  end

  always_comb begin
    case (strobes.lenIdx)
      2'd1:    extWord = extCand[1];
      2'd2:    extWord = extCand[2];
      default: extWord = extCand[0];
    endcase
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      pendLeft  <= '0;
      leftData  <= '0;
      rightData <= '0;
      pairValid <= 1'b0;
    end else begin
      shiftReg <= shiftNext;
      if (strobes.capLeft) begin
        pendLeft <= extWord;
      end
      if (strobes.emitPair) begin
        leftData  <= pendLeft;
        rightData <= extWord;
        pairValid <= 1'b1;
      end else begin
        pairValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 7
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                frameClk,
  input  logic                serData,
  input  logic [1:0]          fmtSel,
  input  logic [1:0]          lenSel,
  output logic [SAMPLE_W-1:0] leftData,
  output logic [SAMPLE_W-1:0] rightData,
  output logic                pairValid
);

  strobes_t strobes;

  serial_audio_rx_ctrl #(
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W)
  ) ctrl_i (
    .bitClk  (bitClk),
    .rstN    (rstN),
    .frameClk(frameClk),
    .fmtSel  (fmtSel),
    .lenSel  (lenSel),
    .strobes (strobes)
  );

  serial_audio_rx_dp #(
    .SAMPLE_W(SAMPLE_W)
  ) dp_i (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .serData  (serData),
    .strobes  (strobes),
    .leftData (leftData),
    .rightData(rightData),
    .pairValid(pairValid)
  );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                bitClk,
  input logic                rstN,
  input logic                frameClk,
  input logic [1:0]          lenSel,
  input logic [SAMPLE_W-1:0] leftData,
  input logic [SAMPLE_W-1:0] rightData,
  input logic                pairValid
);

  localparam int EXT_TOP = SAMPLE_W - 9;

  logic seenPrev;
  logic prevF;
  logic seenRise;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      seenPrev <= 1'b0;
      prevF    <= 1'b0;
      seenRise <= 1'b0;
    end else begin
      seenPrev <= 1'b1;
      prevF    <= frameClk;
      if (seenPrev && frameClk && !prevF) begin
        seenRise <= 1'b1;
      end
    end
  end

  p_idle_before_arm_r1: assert property (@(posedge bitClk) disable iff (!rstN)
    !seenRise |-> !pairValid);

  p_single_pulse_r8: assert property (@(posedge bitClk) disable iff (!rstN)
    pairValid |=> !pairValid);

  p_hold_outputs_r8: assert property (@(posedge bitClk) disable iff (!rstN)
    !pairValid |-> ($stable(leftData) && $stable(rightData)));

  p_sign_ext_r7: assert property (@(posedge bitClk) disable iff (!rstN)
    (pairValid && lenSel == 2'd2) |->
      ((leftData[SAMPLE_W-1:EXT_TOP] == '0 || leftData[SAMPLE_W-1:EXT_TOP] == '1) &&
       (rightData[SAMPLE_W-1:EXT_TOP] == '0 || rightData[SAMPLE_W-1:EXT_TOP] == '1)));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .bitClk   (bitClk),
  .rstN     (rstN),
  .frameClk (frameClk),
  .lenSel   (lenSel),
  .leftData (leftData),
  .rightData(rightData),
  .pairValid(pairValid)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        bitClk   = 1'b0;
  logic        rstN     = 1'b0;
  logic        frameClk = 1'b0;
  logic        serData  = 1'b0;
  logic [1:0]  fmtSel   = 2'd0;
  logic [1:0]  lenSel   = 2'd0;
  logic [23:0] leftData;
  logic [23:0] rightData;
  logic        pairValid;

  int    checks   = 0;
  int    fails    = 0;
  bit    finished = 1'b0;
  string curReq   = "R1";
  int    gapEvery = 0;

  // slot stream: frame level, data bit, event (1 left, 2 right), word value
  bit          qF[$];
  bit          qD[$];
  int          qE[$];
  logic [23:0] qV[$];

  // reference model state
  bit          mPrev, mHavePrev, mArmed, mHaveL, mExpV;
  logic [23:0] mPendL, mExpL, mExpR;
  int          rjEv;
  logic [23:0] rjVal;

  serial_audio_rx dut_i (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .frameClk (frameClk),
    .serData  (serData),
    .fmtSel   (fmtSel),
    .lenSel   (lenSel),
    .leftData (leftData),
    .rightData(rightData),
    .pairValid(pairValid)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    #(CLK_PERIOD / 2) bitClk = 1'b1;
    #(CLK_PERIOD / 2) bitClk = 1'b0;
  endtask

  function automatic logic [23:0] sext(input logic [23:0] raw, input int len);
    logic [23:0] m;
    m = 24'hFFFFFF << len;
    return raw[len-1] ? (raw | m) : (raw & ~m);
  endfunction

  function automatic bit junk();
    return bit'($urandom_range(0, 1));
  endfunction

  task automatic pushSlot(input bit f, input bit d, input int ev, input logic [23:0] v);
    qF.push_back(f);
    qD.push_back(d);
    qE.push_back(ev);
    qV.push_back(v);
  endtask

  task automatic buildFrame(input logic [1:0] fmt, input int len, input logic [23:0] lw, input logic [23:0] rw);
    logic [23:0] sl, sr;
    sl = sext(lw, len);
    sr = sext(rw, len);
    case (fmt)
      2'd1: begin // R3 left-justified: MSB at first slot, high = left
        for (int i = len - 1; i >= 0; i--) pushSlot(1'b1, lw[i], (i == 0) ? 1 : 0, sl);
        for (int k = len; k < 32; k++) pushSlot(1'b1, junk(), 0, '0);
        for (int i = len - 1; i >= 0; i--) pushSlot(1'b0, rw[i], (i == 0) ? 2 : 0, sr);
        for (int k = len; k < 32; k++) pushSlot(1'b0, junk(), 0, '0);
      end
      2'd0: begin // R2 I2S: one slot delay, low = left
        pushSlot(1'b0, junk(), 0, '0);
        for (int i = len - 1; i >= 0; i--) pushSlot(1'b0, lw[i], (i == 0) ? 1 : 0, sl);
        for (int k = len + 1; k < 32; k++) pushSlot(1'b0, junk(), 0, '0);
        pushSlot(1'b1, junk(), 0, '0);
        for (int i = len - 1; i >= 0; i--) pushSlot(1'b1, rw[i], (i == 0) ? 2 : 0, sr);
        for (int k = len + 1; k < 32; k++) pushSlot(1'b1, junk(), 0, '0);
      end
      2'd2: begin // R4 right-justified: LSB just before the change
        for (int s = 0; s < 32; s++)
          pushSlot(1'b1, (s < 32 - len) ? junk() : lw[31 - s], (s == 0) ? rjEv : 0, rjVal);
        rjEv  = 1;
        rjVal = sl;
        for (int s = 0; s < 32; s++)
          pushSlot(1'b0, (s < 32 - len) ? junk() : rw[31 - s], (s == 0) ? rjEv : 0, rjVal);
        rjEv  = 2;
        rjVal = sr;
      end
      default: begin // R5 DSP: pulse, left, right back to back
        pushSlot(1'b1, junk(), 0, '0);
        for (int i = len - 1; i >= 0; i--) pushSlot(1'b0, lw[i], (i == 0) ? 1 : 0, sl);
        for (int i = len - 1; i >= 0; i--) pushSlot(1'b0, rw[i], (i == 0) ? 2 : 0, sr);
        for (int k = 2 * len + 1; k < 64; k++) pushSlot(1'b0, junk(), 0, '0);
      end
    endcase
  endtask

  task automatic compareOutputs(input string tag);
    check(pairValid === mExpV, {"R8 ", tag}, 48'(pairValid), 48'(mExpV));
    check(leftData === mExpL && rightData === mExpR, tag, {leftData, rightData}, {mExpL, mExpR});
  endtask

  task automatic modelStep(input bit f, input int ev, input logic [23:0] v);
    if (mHavePrev && f && !mPrev) mArmed = 1'b1;
    mHavePrev = 1'b1;
    mPrev     = f;
    mExpV     = 1'b0;
    if (mArmed && ev == 1) begin
      mPendL = v;
      mHaveL = 1'b1;
    end else if (mArmed && ev == 2 && mHaveL) begin
      mExpV  = 1'b1;
      mExpL  = mPendL;
      mExpR  = v;
      mHaveL = 1'b0;
    end
  endtask

  task automatic play();
    int slotCnt;
    bit f;
    bit d;
    int e;
    logic [23:0] v;
    slotCnt = 0;
    while (qF.size() > 0) begin
      f = qF.pop_front();
      d = qD.pop_front();
      e = qE.pop_front();
      v = qV.pop_front();
      frameClk = f;
      serData  = d;
      tick();
      modelStep(f, e, v);
      compareOutputs(curReq);
      slotCnt++;
      if (gapEvery > 0 && (slotCnt % gapEvery) == 0) begin
        #(CLK_PERIOD * 5);
        compareOutputs("R9 stalled clock");
      end
    end
  endtask

  task automatic doReset(input bit idleLvl);
    rstN     = 1'b0;
    frameClk = idleLvl;
    serData  = 1'b1;
    tick();
    tick();
    // R1: outputs cleared while reset is held
    check(leftData === '0 && rightData === '0, "R1 reset data", {leftData, rightData}, 48'd0);
    check(pairValid === 1'b0, "R1 reset valid", 48'(pairValid), 48'd0);
    mHavePrev = 1'b0;
    mArmed    = 1'b0;
    mHaveL    = 1'b0;
    mExpV     = 1'b0;
    mExpL     = '0;
    mExpR     = '0;
    mPendL    = '0;
    mPrev     = 1'b0;
    rstN      = 1'b1;
  endtask

  task automatic runSeg(input string req, input logic [1:0] fmt, input logic [1:0] lcode,
                        input bit idleLvl, input int nFrames, input int gap);
    int len;
    logic [23:0] lw, rw, mask;
    len      = (lcode == 2'd1) ? 20 : (lcode == 2'd2) ? 16 : 24;
    mask     = ~(24'hFFFFFF << len);
    curReq   = req;
    gapEvery = gap;
    fmtSel   = fmt;
    lenSel   = lcode;
    doReset(idleLvl);
    rjEv  = 0;
    rjVal = '0;
    // R1: idle slots before any frame edge, data toggling
    for (int i = 0; i < 3; i++) pushSlot(idleLvl, junk(), 0, '0);
    for (int n = 0; n < nFrames; n++) begin
      if (n == 1) begin
        lw = 24'd1 << (len - 1);          // most negative (R7)
        rw = (24'd1 << (len - 1)) - 24'd1; // most positive
      end else if (n == 2) begin
        lw = mask;                         // minus one (R7)
        rw = '0;
      end else begin
        lw = 24'($urandom) & mask;
        rw = 24'($urandom) & mask;
      end
      buildFrame(fmt, len, lw, rw);
    end
    if (fmt == 2'd2) begin
      // closing edge so the last right-justified right word is taken (R4)
      pushSlot(1'b1, junk(), rjEv, rjVal);
      for (int i = 0; i < 3; i++) pushSlot(1'b1, junk(), 0, '0);
    end
    play();
  endtask

  initial begin
    runSeg("R3", 2'd1, 2'd0, 1'b1, 4, 0);   // left-justified 24, idle high at release
    runSeg("R2", 2'd0, 2'd0, 1'b0, 4, 0);   // I2S 24, first right word dropped
    runSeg("R7", 2'd0, 2'd2, 1'b0, 4, 0);   // I2S 16, sign extension
    runSeg("R9", 2'd1, 2'd1, 1'b0, 4, 7);   // left-justified 20 with stalled bit clock
    runSeg("R4", 2'd2, 2'd0, 1'b0, 4, 0);   // right-justified 24
    runSeg("R4", 2'd2, 2'd2, 1'b0, 3, 0);   // right-justified 16
    runSeg("R5", 2'd3, 2'd0, 1'b0, 4, 0);   // DSP 24
    runSeg("R6", 2'd3, 2'd3, 1'b0, 3, 0);   // DSP with length code 3 = 24
    runSeg("R5", 2'd3, 2'd1, 1'b0, 3, 13);  // DSP 20 with stalled bit clock
    doReset(1'b0);                          // R1: pair registers cleared again
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule